// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block drives the background side of a tile-based video renderer. It is given the current scanline and dot from an external raster counter. On every line that renders, it issues a fixed pattern of byte reads into video memory, four reads per 8-dot tile slot: the tile number, the colour-attribute byte and the two bit-planes of the tile row. The read addresses come straight out of a packed 15-bit scroll/position register (the "current" register). The block keeps that register itself and steps it as the beam moves, so the fetches walk across and down the tile map with wrap-around between the map pages.

A host can load the current register at any time through a write strobe. The horizontal and vertical parts of a second 15-bit register (the "staged" value, held outside) are copied into it at fixed points in the line. Each completed slot is handed to the pixel stage as one record. The record holds the tile number, the attribute byte, both bit-planes, the 2-bit palette selection already extracted from the attribute byte, and the fine horizontal scroll that applied at that moment.

The memory is read combinationally: `rd_data_i` must answer the `rd_addr_o` of the same cycle. The raster counter must present each dot for exactly one clock.

Top module: `bg_fetch_seq`

The packed register layout is as follows. Bits 4:0 hold coarse X. Bits 9:5 hold coarse Y. Bit 10 is the horizontal page and bit 11 the vertical page. Bits 14:12 hold fine Y.

A line renders when `render_en_i` is 1 and the line is either below VIS_LINES or equal to PRE_LINE. Phase means (dot − 1) mod 8. All events below act at the clock edge that ends the cycle in which the dot is presented.

## Requirements
- R1: After reset, `v_addr_o` is 0, `tile_valid_o` is 0 and `rd_en_o` is 0 while dot 0 is presented.
- R2: On a rendering line, `rd_en_o` is 1 exactly on dots 1–256 and 321–336 whose phase is 1, 3, 5 or 7. Phase 1 reads the tile number, phase 3 the attribute, phase 5 the low plane and phase 7 the high plane. `rd_en_o` is 0 on every other dot, including dot 0.
- R3: The tile-number read address is 0x2000 | v[11:0].
- R4: The attribute read address is 0x23C0 | v[11:10]<<10 | (coarse Y>>2)<<3 | (coarse X>>2).
- R5: The plane read address is (`pat_hi_i` ? 0x1000 : 0) | tile<<4 | plane<<3 | fine Y. Here tile is the byte read at phase 1 of the same slot, and plane is 0 for the low plane and 1 for the high plane.
- R6: In the cycle after each phase-7 edge, `tile_valid_o` is 1 for one cycle. In that cycle the record carries the slot's tile number, attribute byte, low plane, high plane and the `fine_x_i` value seen at that edge. The record holds its value until the next slot completes.
- R7: The palette output `tile_pal_o` is (attribute >> s) & 3, where s = 4·coarseY[1] + 2·coarseX[1], taken from v at the attribute read.
- R8: At each phase-7 edge inside the fetch windows, coarse X steps by one. From 31 it goes to 0 and v bit 10 flips.
- R9: At dot 256, fine Y steps by one. From 7 it goes to 0 and coarse Y steps. Coarse Y 29 goes to 0 and flips v bit 11. Coarse Y 31 goes to 0 with no flip.
- R10: At dot 257, coarse X and v bit 10 are copied from `t_addr_i`.
- R11: On the pre-render line, during dots 280–304, fine Y, coarse Y and v bit 11 are copied from `t_addr_i`.
- R12: While `render_en_i` is 0, no read is issued, v is left unchanged and no record is produced.
- R13: A cycle with `v_wr_i` = 1 loads `v_wr_data_i` into v. This load overrides any update on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | LINE_W | Current scanline |
| dot_i | input | DOT_W | Current dot in the line |
| render_en_i | input | 1 | Background rendering enable |
| pat_hi_i | input | 1 | Selects the upper pattern half (0x1000) |
| t_addr_i | input | 15 | Staged scroll/position value |
| fine_x_i | input | 3 | Fine horizontal scroll, forwarded with each record |
| v_wr_i | input | 1 | Load strobe for the current register |
| v_wr_data_i | input | 15 | Value loaded by v_wr_i |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 14 | Memory read address |
| rd_data_i | input | 8 | Read data, same cycle as rd_addr_o |
| v_addr_o | output | 15 | Current scroll/position register |
| tile_valid_o | output | 1 | One-cycle pulse: a new tile record is valid |
| tile_idx_o | output | 8 | Record: tile number |
| tile_attr_o | output | 8 | Record: attribute byte |
| tile_lo_o | output | 8 | Record: low bit-plane |
| tile_hi_o | output | 8 | Record: high bit-plane |
| tile_pal_o | output | 2 | Record: palette selection |
| tile_fine_x_o | output | 3 | Record: fine horizontal scroll |

## Verification
The bench builds the block with VIS_LINES = 3 and PRE_LINE = 5 and keeps the full dot timing. A whole frame is then only six lines of 341 dots, so every dot of every line type (visible, idle and pre-render) can be swept in each frame. Across these frames the staged value is chosen to drive coarse Y through its 29 and 31 wraps, to drive coarse X through its 31 wrap during the pre-fetch slots, and to cover every attribute quadrant. Further frames test rendering switched off and a host load landing in the middle of a fetch slot. The bench compares every read address, every record field and the register value on every dot.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

   typedef struct packed {
      logic [2:0] fine_y;
      logic       page_y;
      logic       page_x;
      logic [4:0] coarse_y;
      logic [4:0] coarse_x;
   } scroll_t;

   typedef enum logic [1:0] {
      FK_TILE  = 2'd0,
      FK_ATTR  = 2'd1,
      FK_PLANE0 = 2'd2,
      FK_PLANE1 = 2'd3
   } fetch_kind_e;

   typedef struct packed {
      logic [7:0] tile;
      logic [7:0] attr;
      logic [7:0] plane0;
      logic [7:0] plane1;
      logic [1:0] pal;
      logic [2:0] fine_x;
   } tile_rec_t;

   localparam int unsigned SLOT_DOTS = 8;

   function automatic scroll_t step_x(input scroll_t s);
      scroll_t r = s;
      if (s.coarse_x == 5'd31) begin
         r.coarse_x = 5'd0;
         r.page_x   = ~s.page_x;
      end else begin
         r.coarse_x = s.coarse_x + 5'd1;
      end
      return r;
   endfunction

   function automatic scroll_t step_y(input scroll_t s, input logic [4:0] last_row);
      scroll_t r = s;
      if (s.fine_y != 3'd7) begin
         r.fine_y = s.fine_y + 3'd1;
      end else begin
         r.fine_y = 3'd0;
         if (s.coarse_y == last_row) begin
            r.coarse_y = 5'd0;
            r.page_y   = ~s.page_y;
         end else if (s.coarse_y == 5'd31) begin
            r.coarse_y = 5'd0;
         end else begin
            r.coarse_y = s.coarse_y + 5'd1;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/bgf_timing.sv
module bgf_timing
   import bgf_pkg::*;
#(
   parameter int unsigned DOT_W          = 9,
   parameter int unsigned LINE_W         = 9,
   parameter int unsigned VIS_LINES      = 240,
   parameter int unsigned PRE_LINE       = 261,
   parameter int unsigned FETCH_END      = 256,
   parameter int unsigned PREFETCH_START = 321,
   parameter int unsigned PREFETCH_END   = 336,
   parameter int unsigned VRL_START      = 280,
   parameter int unsigned VRL_END        = 304
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [DOT_W-1:0]  dot_i,
   input  logic              render_en_i,
   output logic              fetch_o,
   output fetch_kind_e       kind_o,
   output logic              inc_x_o,
   output logic              inc_y_o,
   output logic              hreload_o,
   output logic              vreload_o
);

   localparam int unsigned HRELOAD_DOT = FETCH_END + 1;

   logic [2:0] phase;
   logic       in_main;
   logic       in_pre;
   logic       in_window;
   logic       is_pre_line;
   logic       line_ok;
   logic       active;

   always_comb begin
      phase       = dot_i[2:0] - 3'd1;
      in_main     = (dot_i >= DOT_W'(1)) && (dot_i <= DOT_W'(FETCH_END));
      in_pre      = (dot_i >= DOT_W'(PREFETCH_START)) && (dot_i <= DOT_W'(PREFETCH_END));
      in_window   = in_main || in_pre;
      is_pre_line = (line_i == LINE_W'(PRE_LINE));
      line_ok     = (line_i < LINE_W'(VIS_LINES)) || is_pre_line;
      active      = render_en_i && line_ok;

      fetch_o   = active && in_window && phase[0];
      kind_o    = fetch_kind_e'(phase[2:1]);
      inc_x_o   = active && in_window && (phase == 3'd7);
      inc_y_o   = active && (dot_i == DOT_W'(FETCH_END));
      hreload_o = active && (dot_i == DOT_W'(HRELOAD_DOT));
      vreload_o = active && is_pre_line &&
                  (dot_i >= DOT_W'(VRL_START)) && (dot_i <= DOT_W'(VRL_END));
   end

endmodule

// File: rtl/bgf_addr.sv
module bgf_addr
   import bgf_pkg::*;
(
   input  scroll_t     v_i,
   input  fetch_kind_e kind_i,
   input  logic [7:0]  tile_i,
   input  logic        pat_hi_i,
   output logic [13:0] addr_o
);

   always_comb begin
      unique case (kind_i)
         FK_TILE:   addr_o = {2'b10, v_i.page_y, v_i.page_x, v_i.coarse_y, v_i.coarse_x};
         FK_ATTR:   addr_o = {2'b10, v_i.page_y, v_i.page_x, 4'b1111,
                              v_i.coarse_y[4:2], v_i.coarse_x[4:2]};
         FK_PLANE0: addr_o = {1'b0, pat_hi_i, tile_i, 1'b0, v_i.fine_y};
         default:   addr_o = {1'b0, pat_hi_i, tile_i, 1'b1, v_i.fine_y};
      endcase
   end

endmodule

// File: rtl/bgf_vreg.sv
module bgf_vreg
   import bgf_pkg::*;
#(
   parameter int unsigned LAST_ROW = 29
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_i,
   input  scroll_t wr_data_i,
   input  scroll_t t_i,
   input  logic    inc_x_i,
   input  logic    inc_y_i,
   input  logic    hreload_i,
   input  logic    vreload_i,
   output scroll_t v_o
);

   localparam logic [4:0] LAST_ROW_V = 5'(LAST_ROW);

   scroll_t v_q;
   scroll_t v_nxt;

   always_comb begin
      v_nxt = v_q;
      if (inc_x_i) v_nxt = step_x(v_nxt);
      if (inc_y_i) v_nxt = step_y(v_nxt, LAST_ROW_V);
      if (hreload_i) begin
         v_nxt.coarse_x = t_i.coarse_x;
         v_nxt.page_x   = t_i.page_x;
      end
      if (vreload_i) begin
         v_nxt.fine_y   = t_i.fine_y;
         v_nxt.page_y   = t_i.page_y;
         v_nxt.coarse_y = t_i.coarse_y;
      end
      if (wr_i) v_nxt = wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= v_nxt;
   end

   assign v_o = v_q;

endmodule

// File: rtl/bgf_tile_cap.sv
module bgf_tile_cap
   import bgf_pkg::*;
#(
   parameter int unsigned NUM_HELD = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fetch_i,
   input  fetch_kind_e kind_i,
   input  logic [7:0]  rd_data_i,
   input  logic        emit_i,
   input  logic        cx1_i,
   input  logic        cy1_i,
   input  logic [2:0]  fine_x_i,
   output logic [7:0]  tile_o,
   output logic        valid_o,
   output tile_rec_t   rec_o
);

   logic [7:0] held_q [NUM_HELD];
   logic [1:0] pal_q;
   logic [2:0] shift;
   logic       valid_q;
   tile_rec_t  rec_q;

   for (genvar k = 0; k < NUM_HELD; k++) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_q[k] <= '0;
         else if (fetch_i && (kind_i == fetch_kind_e'(2'(k))))
            held_q[k] <= rd_data_i;
      end
   end

   assign shift = {cy1_i, cx1_i, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pal_q <= '0;
      else if (fetch_i && (kind_i == FK_ATTR))
         pal_q <= 2'(rd_data_i >> shift);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rec_q   <= '0;
      end else begin
         valid_q <= emit_i;
         if (emit_i) begin
            rec_q.tile   <= held_q[FK_TILE];
            rec_q.attr   <= held_q[FK_ATTR];
            rec_q.plane0 <= held_q[FK_PLANE0];
            rec_q.plane1 <= rd_data_i;
            rec_q.pal    <= pal_q;
            rec_q.fine_x <= fine_x_i;
         end
      end
   end

   assign tile_o  = held_q[FK_TILE];
   assign valid_o = valid_q;
   assign rec_o   = rec_q;

endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
   import bgf_pkg::*;
#(
   parameter int unsigned DOT_W          = 9,
   parameter int unsigned LINE_W         = 9,
   parameter int unsigned VIS_LINES      = 240,
   parameter int unsigned PRE_LINE       = 261,
   parameter int unsigned FETCH_END      = 256,
   parameter int unsigned PREFETCH_START = 321,
   parameter int unsigned PREFETCH_END   = 336,
   parameter int unsigned VRL_START      = 280,
   parameter int unsigned VRL_END        = 304,
   parameter int unsigned LAST_ROW       = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_i,
   input  logic [DOT_W-1:0]  dot_i,
   input  logic              render_en_i,
   input  logic              pat_hi_i,
   input  logic [14:0]       t_addr_i,
   input  logic [2:0]        fine_x_i,
   input  logic              v_wr_i,
   input  logic [14:0]       v_wr_data_i,
   output logic              rd_en_o,
   output logic [13:0]       rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic [14:0]       v_addr_o,
   output logic              tile_valid_o,
   output logic [7:0]        tile_idx_o,
   output logic [7:0]        tile_attr_o,
   output logic [7:0]        tile_lo_o,
   output logic [7:0]        tile_hi_o,
   output logic [1:0]        tile_pal_o,
   output logic [2:0]        tile_fine_x_o
);

   localparam int unsigned PRE_SLOTS = (PREFETCH_END - PREFETCH_START + 1) / SLOT_DOTS;

   initial begin
      assert (FETCH_END % SLOT_DOTS == 0)
         else $error("FETCH_END must end a slot");
      assert (PREFETCH_START % SLOT_DOTS == 1)
         else $error("PREFETCH_START must begin a slot");
      assert (PRE_SLOTS * SLOT_DOTS == PREFETCH_END - PREFETCH_START + 1)
         else $error("pre-fetch window must be whole slots");
      assert (PREFETCH_END < (1 << DOT_W))
         else $error("DOT_W too narrow");
      assert (PRE_LINE >= VIS_LINES && PRE_LINE < (1 << LINE_W))
         else $error("PRE_LINE out of range");
      assert (VRL_START > FETCH_END + 1 && VRL_END < PREFETCH_START && VRL_START <= VRL_END)
         else $error("vertical reload window misplaced");
      assert (LAST_ROW < 31)
         else $error("LAST_ROW must be below 31");
   end

   logic        fetch;
   fetch_kind_e kind;
   logic        inc_x, inc_y, hreload, vreload;
   scroll_t     v;
   logic [7:0]  cur_tile;
   tile_rec_t   rec;

   bgf_timing #(
      .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE),
      .FETCH_END(FETCH_END), .PREFETCH_START(PREFETCH_START), .PREFETCH_END(PREFETCH_END),
      .VRL_START(VRL_START), .VRL_END(VRL_END)
   ) i_timing (
      .line_i(line_i), .dot_i(dot_i), .render_en_i(render_en_i),
      .fetch_o(fetch), .kind_o(kind), .inc_x_o(inc_x), .inc_y_o(inc_y),
      .hreload_o(hreload), .vreload_o(vreload)
   );

   bgf_vreg #(.LAST_ROW(LAST_ROW)) i_vreg (
      .clk(clk), .rst_n(rst_n),
      .wr_i(v_wr_i), .wr_data_i(scroll_t'(v_wr_data_i)), .t_i(scroll_t'(t_addr_i)),
      .inc_x_i(inc_x), .inc_y_i(inc_y), .hreload_i(hreload), .vreload_i(vreload),
      .v_o(v)
   );

   bgf_addr i_addr (
      .v_i(v), .kind_i(kind), .tile_i(cur_tile), .pat_hi_i(pat_hi_i), .addr_o(rd_addr_o)
   );

   bgf_tile_cap #(.NUM_HELD(3)) i_cap (
      .clk(clk), .rst_n(rst_n),
      .fetch_i(fetch), .kind_i(kind), .rd_data_i(rd_data_i), .emit_i(inc_x),
      .cx1_i(v.coarse_x[1]), .cy1_i(v.coarse_y[1]), .fine_x_i(fine_x_i),
      .tile_o(cur_tile), .valid_o(tile_valid_o), .rec_o(rec)
   );

   assign rd_en_o       = fetch;
   assign v_addr_o      = v;
   assign tile_idx_o    = rec.tile;
   assign tile_attr_o   = rec.attr;
   assign tile_lo_o     = rec.plane0;
   assign tile_hi_o     = rec.plane1;
   assign tile_pal_o    = rec.pal;
   assign tile_fine_x_o = rec.fine_x;

endmodule

// File: rtl/bgf_checker.sv
module bgf_checker #(
   parameter int unsigned DOT_W     = 9,
   parameter int unsigned LINE_W    = 9,
   parameter int unsigned VIS_LINES = 240,
   parameter int unsigned PRE_LINE  = 261,
   parameter int unsigned FETCH_END = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LINE_W-1:0] line_i,
   input logic [DOT_W-1:0]  dot_i,
   input logic              render_en_i,
   input logic              pat_hi_i,
   input logic [14:0]       t_addr_i,
   input logic              v_wr_i,
   input logic [14:0]       v_wr_data_i,
   input logic              rd_en_o,
   input logic [13:0]       rd_addr_o,
   input logic [14:0]       v_addr_o,
   input logic              tile_valid_o
);

   logic line_ok;
   assign line_ok = (line_i < LINE_W'(VIS_LINES)) || (line_i == LINE_W'(PRE_LINE));

   p_rd_even_dot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> (dot_i[0] == 1'b0) && render_en_i && line_ok);

   p_tile_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && dot_i[2:0] == 3'b010) |-> (rd_addr_o[13:12] == 2'b10));

   p_attr_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && dot_i[2:0] == 3'b100) |-> (rd_addr_o[13:6] == 8'b1000_1111 ||
                                            rd_addr_o[13:6] == 8'b1001_1111 ||
                                            rd_addr_o[13:6] == 8'b1010_1111 ||
                                            rd_addr_o[13:6] == 8'b1011_1111));

   p_plane_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && !rd_addr_o[13]) |-> (rd_addr_o[12] == pat_hi_i) &&
                                      (dot_i[2:0] == 3'b110 || dot_i[2:0] == 3'b000));

   p_tile_after_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tile_valid_o |-> $past(rd_en_o && rd_addr_o[3] && !rd_addr_o[13]));

   p_tile_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tile_valid_o |=> !tile_valid_o);

   p_hreload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (render_en_i && line_ok && !v_wr_i && dot_i == DOT_W'(FETCH_END + 1)) |=>
         (v_addr_o[10] == $past(t_addr_i[10])) && (v_addr_o[4:0] == $past(t_addr_i[4:0])));

   p_off_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!render_en_i && !v_wr_i) |=> $stable(v_addr_o));

   p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      v_wr_i |=> (v_addr_o == $past(v_wr_data_i)));

endmodule

bind bg_fetch_seq bgf_checker #(
   .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES),
   .PRE_LINE(PRE_LINE), .FETCH_END(FETCH_END)
) i_bgf_checker (
   .clk(clk), .rst_n(rst_n), .line_i(line_i), .dot_i(dot_i),
   .render_en_i(render_en_i), .pat_hi_i(pat_hi_i), .t_addr_i(t_addr_i),
   .v_wr_i(v_wr_i), .v_wr_data_i(v_wr_data_i), .rd_en_o(rd_en_o),
   .rd_addr_o(rd_addr_o), .v_addr_o(v_addr_o), .tile_valid_o(tile_valid_o)
);

// File: tb/test_bg_fetch_seq.sv
`timescale 1ns/100ps
module test_bg_fetch_seq;

   localparam int VIS = 3;
   localparam int PRE = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  line_i = '0;
   logic [8:0]  dot_i = '0;
   logic        render_en_i = 1'b0;
   logic        pat_hi_i = 1'b0;
   logic [14:0] t_addr_i = '0;
   logic [2:0]  fine_x_i = '0;
   logic        v_wr_i = 1'b0;
   logic [14:0] v_wr_data_i = '0;
   logic        rd_en_o;
   logic [13:0] rd_addr_o;
   logic [7:0]  rd_data_i;
   logic [14:0] v_addr_o;
   logic        tile_valid_o;
   logic [7:0]  tile_idx_o, tile_attr_o, tile_lo_o, tile_hi_o;
   logic [1:0]  tile_pal_o;
   logic [2:0]  tile_fine_x_o;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] memf(input logic [13:0] a);
      return a[7:0] ^ {a[13:8], a[13:12]} ^ 8'h3C;
   endfunction

   assign rd_data_i = memf(rd_addr_o);

   bg_fetch_seq #(.VIS_LINES(VIS), .PRE_LINE(PRE)) i_bg_fetch_seq (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .dot_i(dot_i),
      .render_en_i(render_en_i), .pat_hi_i(pat_hi_i), .t_addr_i(t_addr_i),
      .fine_x_i(fine_x_i), .v_wr_i(v_wr_i), .v_wr_data_i(v_wr_data_i),
      .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
      .v_addr_o(v_addr_o), .tile_valid_o(tile_valid_o), .tile_idx_o(tile_idx_o),
      .tile_attr_o(tile_attr_o), .tile_lo_o(tile_lo_o), .tile_hi_o(tile_hi_o),
      .tile_pal_o(tile_pal_o), .tile_fine_x_o(tile_fine_x_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [14:0] mv = '0;
   logic [7:0]  m_nt = '0, m_at = '0, m_lo = '0;
   logic [1:0]  m_pal = '0;
   logic        e_valid = 1'b0;
   logic [7:0]  e_idx = '0, e_attr = '0, e_lo = '0, e_hi = '0;
   logic [1:0]  e_pal = '0;
   logic [2:0]  e_fx = '0;
   string       vtag = "R1";

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s line=%0d dot=%0d act=%0h exp=%0h", tag, line_i, dot_i, act, exp);
      end
   endtask

   task automatic step(input int ln, input int dt, input bit ren, input bit wr, input logic [14:0] wv);
      bit          active, infetch, efetch;
      int          ph, kind;
      logic [13:0] ea;
      logic [7:0]  d;
      line_i = 9'(ln); dot_i = 9'(dt); render_en_i = ren;
      pat_hi_i = 1'(ln); fine_x_i = 3'(ln + dt / 8);
      v_wr_i = wr; v_wr_data_i = wv;
      @(negedge clk);
      active  = ren && (ln < VIS || ln == PRE);
      ph      = (dt + 7) % 8;
      infetch = (dt >= 1 && dt <= 256) || (dt >= 321 && dt <= 336);
      efetch  = active && infetch && (ph % 2 == 1);
      kind    = ph / 2;
      chk(ren ? "R2" : "R12", 32'(rd_en_o), 32'(efetch));
      ea = '0;
      if (efetch) begin
         case (kind)
            0: begin ea = 14'h2000 | 14'(mv[11:0]); chk("R3", 32'(rd_addr_o), 32'(ea)); end
            1: begin
               ea = 14'h23C0 | (14'(mv[11:10]) << 10) | (14'(mv[9:7]) << 3) | 14'(mv[4:2]);
               chk("R4", 32'(rd_addr_o), 32'(ea));
            end
            default: begin
               ea = (pat_hi_i ? 14'h1000 : 14'h0) | (14'(m_nt) << 4) |
                    (kind == 3 ? 14'h8 : 14'h0) | 14'(mv[14:12]);
               chk("R5", 32'(rd_addr_o), 32'(ea));
            end
         endcase
      end
      chk(vtag, 32'(v_addr_o), 32'(mv));
      chk("R6", 32'(tile_valid_o), 32'(e_valid));
      if (e_valid) begin
         chk("R6", 32'({tile_idx_o, tile_attr_o, tile_lo_o, tile_hi_o}),
                   32'({e_idx, e_attr, e_lo, e_hi}));
         chk("R6", 32'(tile_fine_x_o), 32'(e_fx));
         chk("R7", 32'(tile_pal_o), 32'(e_pal));
      end
      // expected state after the coming edge
      d = memf(ea);
      e_valid = 1'b0;
      if (efetch) begin
         case (kind)
            0: m_nt = d;
            1: begin m_at = d; m_pal = 2'(d >> (mv[6] * 4 + mv[1] * 2)); end
            2: m_lo = d;
            default: begin
               e_valid = 1'b1; e_idx = m_nt; e_attr = m_at; e_lo = m_lo;
               e_hi = d; e_pal = m_pal; e_fx = fine_x_i;
            end
         endcase
      end
      if (!ren) vtag = "R12";
      if (wr) begin
         mv = wv; vtag = "R13";
      end else if (active) begin
         if (efetch && kind == 3) begin
            vtag = "R8";
            if (mv[4:0] == 5'd31) begin mv[4:0] = 5'd0; mv[10] = ~mv[10]; end
            else mv[4:0] = mv[4:0] + 5'd1;
         end
         if (dt == 256) begin
            vtag = "R9";
            if (mv[14:12] != 3'd7) mv[14:12] = mv[14:12] + 3'd1;
            else begin
               mv[14:12] = 3'd0;
               if (mv[9:5] == 5'd29) begin mv[9:5] = 5'd0; mv[11] = ~mv[11]; end
               else if (mv[9:5] == 5'd31) mv[9:5] = 5'd0;
               else mv[9:5] = mv[9:5] + 5'd1;
            end
         end
         if (dt == 257) begin
            vtag = "R10"; mv[4:0] = t_addr_i[4:0]; mv[10] = t_addr_i[10];
         end
         if (ln == PRE && dt >= 280 && dt <= 304) begin
            vtag = "R11"; mv[14:11] = t_addr_i[14:11]; mv[9:5] = t_addr_i[9:5];
         end
      end
      @(posedge clk); #1;
   endtask

   task automatic run_line(input int ln, input bit ren, input int wr_dot, input logic [14:0] wv);
      for (int dt = 0; dt <= 340; dt++) step(ln, dt, ren, dt == wr_dot, wv);
   endtask

   task automatic run_frame(input logic [14:0] t, input bit ren, input int wr_line,
                            input int wr_dot, input logic [14:0] wv);
      t_addr_i = t;
      run_line(PRE, ren, (wr_line == PRE) ? wr_dot : -1, wv);
      for (int ln = 0; ln < PRE; ln++) run_line(ln, ren, (wr_line == ln) ? wr_dot : -1, wv);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) step(0, 0, 1'b0, 1'b0, '0);
      chk("R1", 32'(v_addr_o), 32'h0);
      chk("R1", 32'(tile_valid_o), 32'h0);
      rst_n = 1'b1;
      step(0, 0, 1'b1, 1'b0, '0);
      // fine Y 7 with coarse Y 29: row wrap with vertical page flip; coarse X start 31
      run_frame({3'd7, 1'b0, 1'b1, 5'd29, 5'd31}, 1'b1, PRE, 0, 15'h1234);
      // coarse Y 31 wraps without flip
      run_frame({3'd7, 1'b1, 1'b0, 5'd31, 5'd30}, 1'b1, -1, -1, '0);
      // other quadrants and mid-row values
      run_frame({3'd2, 1'b0, 1'b0, 5'd10, 5'd6}, 1'b1, -1, -1, '0);
      run_frame({3'd6, 1'b1, 1'b1, 5'd3, 5'd13}, 1'b1, -1, -1, '0);
      // rendering off, with one load
      run_frame(15'h5A5A, 1'b0, 1, 40, 15'h2F0F);
      // load inside a fetch slot while rendering
      run_frame({3'd1, 1'b0, 1'b0, 5'd28, 5'd2}, 1'b1, 1, 101, {3'd7, 1'b1, 1'b0, 5'd29, 5'd31});
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule